// File: doc/BRIEF.md
# Reduced-Power Mode Controller

This block decides which clock domains of a small microcontroller core may toggle. Software selects a sleep state by writing two mode bits, one for a light sleep (idle) and one for a deep sleep (power-down). In idle the processor stops while the timers and the interrupt logic keep running; the converter and PWM clocks are also gated. In power-down every clock enable drops, including the oscillator enable, so nothing advances until the external reset pin is used.

The block also qualifies the external reset pin. The pin is synchronised, and an internal reset is produced only after it has stayed high for a set number of machine cycles. A machine cycle is a fixed number of oscillator periods, and it is counted only while the oscillator is enabled. Leaving power-down therefore takes two steps: the synchronised pin first raises the oscillator enable (state WAKE), and only then does the qualification count start.

States: RUN (all clocks on), IDLE, PDOWN, WAKE. Transitions: RUN to PDOWN on a write with the power-down bit set (this wins over the idle bit). RUN to IDLE on a write with only the idle bit set. IDLE to RUN on a pending enabled interrupt. PDOWN to WAKE when the synchronised pin is high. WAKE to PDOWN when the pin drops before qualification. Any state to RUN while the internal reset is asserted.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After power-on clear the block is in RUN: cpu_clk_en, per_clk_en, ana_clk_en and osc_en are 1, mode_idle, mode_pdown and sys_rst are 0.
- R2: A write in RUN with wr_idle=1 and wr_pdown=0 enters IDLE after that edge: cpu_clk_en=0, ana_clk_en=0, per_clk_en=1, osc_en=1, mode_idle=1.
- R3: In IDLE, irq_pending=1 at an edge returns the block to RUN after that edge with mode_idle cleared; irq_pending has no effect in RUN or PDOWN.
- R4: While sys_rst is 1 the block goes to RUN at the next edge from any state, and both mode bits read 0.
- R5: A write in RUN with wr_pdown=1 enters PDOWN: all four enables are 0 and mode_pdown=1; only the reset pin can leave it.
- R6: sys_rst rises after the synchronised pin has stayed high for QUAL_MC machine cycles of OSC_PER_MC clocks each; in RUN with defaults it is 0 after 25 edges and 1 after 26 edges counting the first edge that sees the pin high; it stays 1 while the pin is high and clears within 3 edges of the pin going low.
- R7: In PDOWN a high pin raises osc_en after the third edge (the block is then in WAKE with cpu_clk_en=0); qualification starts only then, so sys_rst appears one edge later than in R6 (after 27 edges).
- R8: A write with both wr_idle=1 and wr_pdown=1 enters PDOWN, not IDLE.
- R9: A pin pulse shorter than the qualification time produces no sys_rst; in WAKE it returns the block to PDOWN with osc_en=0.
- R10: Writes while not in RUN are ignored: the mode bits do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| rst_pin | input | 1 | Raw external reset pin, active high |
| wr_en | input | 1 | Write strobe of the mode bits |
| wr_idle | input | 1 | Idle request bit of the write |
| wr_pdown | input | 1 | Power-down request bit of the write |
| irq_pending | input | 1 | An enabled interrupt is pending |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Timer and interrupt logic clock enable |
| ana_clk_en | output | 1 | Converter and PWM clock enable |
| osc_en | output | 1 | Oscillator enable |
| sys_rst | output | 1 | Qualified internal reset |
| mode_idle | output | 1 | Idle bit as held in the mode register |
| mode_pdown | output | 1 | Power-down bit as held in the mode register |

## Verification
The assertions take for granted that the write strobe comes only from the running processor and that irq_pending and the write inputs are synchronous to clk; reset pin timing is arbitrary since the pin is synchronised inside. The stimulus changes inputs one nanosecond after a rising edge, keeps writes to single-cycle pulses, and holds the pin high or low for whole counted stretches, including one stretch shorter than the qualification window and one that is aborted during WAKE.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_PDOWN = 2'd2,
        ST_WAKE  = 2'd3
    } lpm_state_e;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/lpm_prescale.sv
// Machine-cycle strobe: one pulse every DIV enabled clocks, phase restarted
// whenever counting is disabled.
module lpm_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    output logic stb
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] phase;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)             phase <= '0;
        else if (!run)          phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign stb = run && (phase == LAST);
endmodule

// File: rtl/lpm_rst_qual.sv
// Counts machine-cycle strobes while the pin is high; saturates at NEED.
module lpm_rst_qual #(
    parameter int NEED = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_hi,
    input  logic stb,
    output logic qualified
);
    localparam int W = $clog2(NEED + 1);
    localparam logic [W-1:0] FULL = W'(NEED);

    logic [W-1:0] count;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                    count <= '0;
        else if (!pin_hi)              count <= '0;
        else if (stb && count != FULL) count <= count + 1'b1;
    end

    assign qualified = (count == FULL);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic wr_en,
    input  logic wr_idle,
    input  logic wr_pdown,
    input  logic irq_pending,
    input  logic pin_hi,
    input  logic sys_rst,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic ana_clk_en,
    output logic osc_en,
    output logic mode_idle,
    output logic mode_pdown
);
    lpm_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (wr_en && wr_pdown)     nxt = ST_PDOWN;
                else if (wr_en && wr_idle) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (irq_pending) nxt = ST_RUN;
            end
            ST_PDOWN: begin
                if (pin_hi) nxt = ST_WAKE;
            end
            ST_WAKE: begin
                if (!pin_hi) nxt = ST_PDOWN;
            end
        endcase
        if (sys_rst) nxt = ST_RUN;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        cpu_clk_en = 1'b0;
        per_clk_en = 1'b0;
        ana_clk_en = 1'b0;
        osc_en     = 1'b1;
        mode_idle  = 1'b0;
        mode_pdown = 1'b0;
        unique case (state)
            ST_RUN: begin
                cpu_clk_en = 1'b1;
                per_clk_en = 1'b1;
                ana_clk_en = 1'b1;
            end
            ST_IDLE: begin
                per_clk_en = 1'b1;
                mode_idle  = 1'b1;
            end
            ST_PDOWN: begin
                osc_en     = 1'b0;
                mode_pdown = 1'b1;
            end
            ST_WAKE: begin
                mode_pdown = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl #(
    parameter int OSC_PER_MC  = 12,
    parameter int QUAL_MC     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    input  logic wr_en,
    input  logic wr_idle,
    input  logic wr_pdown,
    input  logic irq_pending,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic ana_clk_en,
    output logic osc_en,
    output logic sys_rst,
    output logic mode_idle,
    output logic mode_pdown
);
    logic pin_hi;
    logic mc_stb;

    lpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d     (rst_pin),
        .q     (pin_hi)
    );

    lpm_prescale #(.DIV(OSC_PER_MC)) u_pre (
        .clk   (clk),
        .por_n (por_n),
        .run   (pin_hi && osc_en),
        .stb   (mc_stb)
    );

    lpm_rst_qual #(.NEED(QUAL_MC)) u_qual (
        .clk       (clk),
        .por_n     (por_n),
        .pin_hi    (pin_hi),
        .stb       (mc_stb),
        .qualified (sys_rst)
    );

    lpm_fsm u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .wr_en       (wr_en),
        .wr_idle     (wr_idle),
        .wr_pdown    (wr_pdown),
        .irq_pending (irq_pending),
        .pin_hi      (pin_hi),
        .sys_rst     (sys_rst),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .ana_clk_en  (ana_clk_en),
        .osc_en      (osc_en),
        .mode_idle   (mode_idle),
        .mode_pdown  (mode_pdown)
    );
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker (
    input logic clk,
    input logic por_n,
    input logic wr_en,
    input logic wr_idle,
    input logic wr_pdown,
    input logic irq_pending,
    input logic cpu_clk_en,
    input logic per_clk_en,
    input logic ana_clk_en,
    input logic osc_en,
    input logic sys_rst,
    input logic mode_idle,
    input logic mode_pdown
);
    // R2: idle gates processor and analog clocks, keeps peripherals
    a_r2_idle_clocks: assert property (@(posedge clk) disable iff (!por_n)
        mode_idle |-> (!cpu_clk_en && !ana_clk_en && per_clk_en && osc_en));

    // R3: pending interrupt ends idle at the next edge
    a_r3_irq_wakes: assert property (@(posedge clk) disable iff (!por_n)
        (mode_idle && irq_pending) |=> (cpu_clk_en && !mode_idle));

    // R4: qualified reset returns to run
    a_r4_reset_to_run: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (cpu_clk_en && !mode_idle && !mode_pdown));

    // R5: deep sleep leaves only through reset
    a_r5_pdown_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (mode_pdown && !sys_rst) |=> (!cpu_clk_en && !per_clk_en && !ana_clk_en));

    // R6/R7: reset is only qualified while the oscillator is enabled
    a_r7_osc_before_reset: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |-> osc_en);

    // R8: power-down wins when both bits are written
    a_r8_pdown_priority: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_clk_en && wr_en && wr_pdown && !sys_rst) |=> (mode_pdown && !mode_idle));

    // R10: mode bits never both set
    a_r10_one_mode: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({mode_idle, mode_pdown}));
endmodule

bind lp_mode_ctrl lpm_checker u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .wr_en       (wr_en),
    .wr_idle     (wr_idle),
    .wr_pdown    (wr_pdown),
    .irq_pending (irq_pending),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .ana_clk_en  (ana_clk_en),
    .osc_en      (osc_en),
    .sys_rst     (sys_rst),
    .mode_idle   (mode_idle),
    .mode_pdown  (mode_pdown)
);

// File: tb/lp_mode_ctrl_bench.sv
module lp_mode_ctrl_bench;
    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_pin = 1'b0;
    logic wr_en = 1'b0;
    logic wr_idle = 1'b0;
    logic wr_pdown = 1'b0;
    logic irq_pending = 1'b0;
    logic cpu_clk_en, per_clk_en, ana_clk_en, osc_en, sys_rst, mode_idle, mode_pdown;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lp_mode_ctrl u_lp_mode_ctrl (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .wr_en(wr_en),
        .wr_idle(wr_idle), .wr_pdown(wr_pdown), .irq_pending(irq_pending),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .ana_clk_en(ana_clk_en),
        .osc_en(osc_en), .sys_rst(sys_rst), .mode_idle(mode_idle), .mode_pdown(mode_pdown)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    // {cpu, per, ana, osc, idle, pdown}
    task automatic chk_all(input string req, input logic [5:0] exp);
        chk(req, "cpu_clk_en", cpu_clk_en, exp[5]);
        chk(req, "per_clk_en", per_clk_en, exp[4]);
        chk(req, "ana_clk_en", ana_clk_en, exp[3]);
        chk(req, "osc_en",     osc_en,     exp[2]);
        chk(req, "mode_idle",  mode_idle,  exp[1]);
        chk(req, "mode_pdown", mode_pdown, exp[0]);
    endtask

    task automatic write_bits(input logic idl, input logic pd);
        wr_en = 1'b1; wr_idle = idl; wr_pdown = pd;
        tick();
        wr_en = 1'b0; wr_idle = 1'b0; wr_pdown = 1'b0;
    endtask

    task automatic release_pin();
        rst_pin = 1'b0;
        repeat (3) tick();
        chk("R6", "sys_rst after pin low", sys_rst, 1'b0);
    endtask

    task automatic t_power_on();
        repeat (3) tick();
        por_n = 1'b1;
        tick();
        chk_all("R1", 6'b111100);
        chk("R1", "sys_rst", sys_rst, 1'b0);
    endtask

    task automatic t_idle_irq();
        irq_pending = 1'b1;   // R3: no effect in RUN
        tick();
        irq_pending = 1'b0;
        chk_all("R3", 6'b111100);
        write_bits(1'b1, 1'b0);
        chk_all("R2", 6'b010110);
        tick();
        chk_all("R2", 6'b010110);
        write_bits(1'b0, 1'b1);  // R10: ignored while idle
        chk_all("R10", 6'b010110);
        irq_pending = 1'b1;
        tick();
        irq_pending = 1'b0;
        chk_all("R3", 6'b111100);
    endtask

    task automatic t_reset_in_run();
        rst_pin = 1'b1;
        repeat (25) tick();
        chk("R6", "sys_rst after 25 edges", sys_rst, 1'b0);
        tick();
        chk("R6", "sys_rst after 26 edges", sys_rst, 1'b1);
        repeat (4) tick();
        chk("R6", "sys_rst held", sys_rst, 1'b1);
        chk_all("R4", 6'b111100);
        release_pin();
    endtask

    task automatic t_short_pulse();
        logic seen = 1'b0;
        rst_pin = 1'b1;
        repeat (20) begin
            tick();
            if (sys_rst) seen = 1'b1;
        end
        rst_pin = 1'b0;
        repeat (3) begin
            tick();
            if (sys_rst) seen = 1'b1;
        end
        chk("R9", "short pulse reset", seen, 1'b0);
        chk_all("R9", 6'b111100);
    endtask

    task automatic t_pdown_exit();
        write_bits(1'b1, 1'b1);
        chk_all("R8", 6'b000001);
        irq_pending = 1'b1;
        repeat (3) tick();
        irq_pending = 1'b0;
        chk_all("R5", 6'b000001);
        write_bits(1'b1, 1'b0);
        chk_all("R10", 6'b000001);
        rst_pin = 1'b1;
        repeat (2) tick();
        chk("R7", "osc_en after 2 edges", osc_en, 1'b0);
        tick();
        chk_all("R7", 6'b000101);
        repeat (23) tick();
        chk("R7", "sys_rst after 26 edges", sys_rst, 1'b0);
        tick();
        chk("R7", "sys_rst after 27 edges", sys_rst, 1'b1);
        tick();
        chk_all("R4", 6'b111100);
        release_pin();
    endtask

    task automatic t_pdown_abort();
        write_bits(1'b0, 1'b1);
        chk_all("R5", 6'b000001);
        rst_pin = 1'b1;
        repeat (8) tick();
        chk("R9", "osc_en in wake", osc_en, 1'b1);
        rst_pin = 1'b0;
        repeat (3) tick();
        chk_all("R9", 6'b000001);
        chk("R9", "sys_rst", sys_rst, 1'b0);
    endtask

    task automatic t_reset_in_pdown_again();
        rst_pin = 1'b1;
        repeat (28) tick();
        chk_all("R4", 6'b111100);
        release_pin();
    endtask

    task automatic t_reset_in_idle();
        write_bits(1'b1, 1'b0);
        chk_all("R2", 6'b010110);
        rst_pin = 1'b1;
        repeat (26) tick();
        chk("R4", "sys_rst in idle", sys_rst, 1'b1);
        tick();
        chk_all("R4", 6'b111100);
        release_pin();
    endtask

    initial begin
        t_power_on();
        t_idle_irq();
        t_reset_in_run();
        t_short_pulse();
        t_pdown_exit();
        t_pdown_abort();
        t_reset_in_pdown_again();
        t_reset_in_idle();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule